// File: doc/BRIEF.md
# Serial Peripheral Front End with Transfer Hold

This block is the bit-level front end of a serial memory slave. It samples chip select, the serial clock, the hold pin and serial data in the system clock domain through two-stage synchronizers. It finds clock edges there and collects incoming bits into bytes, most significant bit first. On each complete byte it gives a one-cycle strobe. It also reports the start and the end of each transfer with single-cycle pulses. Decoding and memory storage sit outside it.

When the command decoder behind it wants to answer, it holds `tx_req_i` high and presents a byte on `tx_byte_i`. At the next serial clock rising edge that falls on a byte boundary, the block switches to output mode. It then shifts bytes out on every rising edge and reloads `tx_byte_i` at each byte boundary. The output is modelled as a data bit plus a drive enable; a low enable stands for high impedance. The hold pin can freeze a transfer. The freeze and its release only change while the serial clock is high, so a hold request made while the clock is low waits for the next rising edge. The system clock must run at least four times faster than the serial clock.

Top module: `spi_hold_frontend`

## Requirements
- R1: While chip select is high, serial clock and data activity produce no byte strobe and no output drive.
- R2: With chip select low, data is captured on serial clock falling edges, most significant bit first; after eight captures the byte appears on `rx_byte_o` with a one-cycle `rx_valid_o`.
- R3: During the input phase, `so_en_o` stays low.
- R4: When `tx_req_i` is high at a rising edge with zero input bits pending, output starts: `tx_byte_i` is launched most significant bit first, one bit per rising edge. From then on, serial input produces no further byte strobes.
- R5: The serial clock may rest either high or low when chip select falls; in both cases capture is on falling edges and launch is on rising edges.
- R6: The hold state changes only while the synchronized serial clock is high. A hold pin change made while the clock is low takes effect at the next rising edge.
- R7: While the hold state is active, serial clock edges are ignored, and the transfer resumes at the same bit once the hold is released.
- R8: A low hold pin forces `so_en_o` low whether or not the hold state has been entered.
- R9: A rising chip select aborts the transfer: the bit count, the hold state and the output phase are cleared. Each chip select fall gives one `start_o` pulse and each rise gives one `end_o` pulse.
- R10: In output mode, a new `tx_byte_i` is loaded at every byte boundary, so bytes stream back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| hold_n_i | input | 1 | Hold pin, active low |
| si_i | input | 1 | Serial data in |
| tx_byte_i | input | 8 | Byte to send in output mode |
| tx_req_i | input | 1 | Request to enter output mode at the next byte boundary |
| so_o | output | 1 | Serial data out |
| so_en_o | output | 1 | Output drive enable (low = high impedance) |
| rx_byte_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| start_o | output | 1 | Pulse on chip select fall |
| end_o | output | 1 | Pulse on chip select rise |

## Verification
A wrong bit count shows up at the port within one byte: the byte strobe fires at the wrong capture, or the reply starts on the wrong edge. A hold state entered or left at the wrong moment shifts every later bit, so the received or sent byte differs at its next strobe or launch. A stuck output phase shows as `so_en_o` high while a command is still arriving, visible two system clocks after the pin change. The bench models the synchronizer delay and compares every output on every clock, so such faults are reported within a few cycles.

// File: rtl/fe_pkg.sv
package fe_pkg;
    parameter int FE_W = 8;
    localparam int FE_CNT_W = $clog2(FE_W);

    typedef enum logic {
        PH_IN  = 1'b0,
        PH_OUT = 1'b1
    } fe_phase_e;
endpackage

// File: rtl/fe_sync.sv
module fe_sync #(
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] st1_q;
    logic [W-1:0] st2_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st1_q[i] <= RST_VAL[i];
                st2_q[i] <= RST_VAL[i];
            end else begin
                st1_q[i] <= pin_i[i];
                st2_q[i] <= st1_q[i];
            end
        end
    end

    assign sync_o = st2_q;
endmodule

// File: rtl/fe_hold.sv
module fe_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic sck_s_i,
    input  logic hold_s_i,
    output logic held_q_o,
    output logic held_d_o
);
    logic held_d, held_q;

    // The hold state may move only while the serial clock is high.
    always_comb begin
        held_d = held_q;
        if (!active_i) begin
            held_d = 1'b0;
        end else if (sck_s_i) begin
            held_d = !hold_s_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) held_q <= 1'b0;
        else        held_q <= held_d;
    end

    assign held_q_o = held_q;
    assign held_d_o = held_d;

    AST_HOLD_ENTER_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held_q) |-> $past(sck_s_i)); // R6
    AST_HOLD_LEAVE_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(held_q) |-> ($past(sck_s_i) || !$past(active_i))); // R6
endmodule

// File: rtl/fe_shift.sv
module fe_shift
    import fe_pkg::*;
#(
    parameter int W = FE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active_i,
    input  logic         fall_ok_i,
    input  logic         rise_ok_i,
    input  logic         si_s_i,
    input  logic [W-1:0] tx_byte_i,
    input  logic         tx_req_i,
    output logic         out_phase_o,
    output logic         out_bit_o,
    output logic [W-1:0] rx_byte_o,
    output logic         rx_valid_o
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        fe_phase_e      phase;
        logic [CW-1:0]  cnt;
        logic [W-1:0]   in_sr;
        logic [W-1:0]   out_sr;
        logic [W-1:0]   rx_byte;
        logic           rx_valid;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.rx_valid = 1'b0;
        if (!active_i) begin
            st_d.phase = PH_IN;
            st_d.cnt   = '0;
        end else begin
            if (fall_ok_i && st_q.phase == PH_IN) begin
                st_d.in_sr = {st_q.in_sr[W-2:0], si_s_i};
                if (st_q.cnt == LAST) begin
                    st_d.rx_valid = 1'b1;
                    st_d.rx_byte  = {st_q.in_sr[W-2:0], si_s_i};
                    st_d.cnt      = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end
            if (rise_ok_i) begin
                if (st_q.phase == PH_IN) begin
                    if (st_q.cnt == '0 && tx_req_i) begin
                        st_d.phase  = PH_OUT;
                        st_d.out_sr = tx_byte_i;
                        st_d.cnt    = CW'(1);
                    end
                end else begin
                    st_d.out_sr = (st_q.cnt == '0) ? tx_byte_i : {st_q.out_sr[W-2:0], 1'b0};
                    st_d.cnt    = (st_q.cnt == LAST) ? '0 : st_q.cnt + CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IN, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_phase_o = (st_q.phase == PH_OUT);
    assign out_bit_o   = st_q.out_sr[W-1];
    assign rx_byte_o   = st_q.rx_byte;
    assign rx_valid_o  = st_q.rx_valid;

    AST_NO_RX_IN_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rx_valid |-> $past(st_q.phase == PH_IN)); // R4
endmodule

// File: rtl/spi_hold_frontend.sv
module spi_hold_frontend
    import fe_pkg::*;
#(
    parameter int W = FE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n_i,
    input  logic         sck_i,
    input  logic         hold_n_i,
    input  logic         si_i,
    input  logic [W-1:0] tx_byte_i,
    input  logic         tx_req_i,
    output logic         so_o,
    output logic         so_en_o,
    output logic [W-1:0] rx_byte_o,
    output logic         rx_valid_o,
    output logic         start_o,
    output logic         end_o
);
    typedef struct packed {
        logic cs_p;
        logic sck_p;
        logic start;
        logic stop;
    } top_st_t;

    logic [3:0] pins_s;
    logic cs_s, sck_s, hold_s, si_s;
    logic active, held_q, held_d, fall_ok, rise_ok, out_phase;
    top_st_t st_d, st_q;

    // Idle values: chip select high, clock low, hold released, data low.
    fe_sync #(.W(4), .RST_VAL(4'b1010)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({cs_n_i, sck_i, hold_n_i, si_i}),
        .sync_o (pins_s)
    );
    assign {cs_s, sck_s, hold_s, si_s} = pins_s;
    assign active = !cs_s;

    always_comb begin
        st_d       = st_q;
        st_d.cs_p  = cs_s;
        st_d.sck_p = sck_s;
        st_d.start = st_q.cs_p && !cs_s;
        st_d.stop  = !st_q.cs_p && cs_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cs_p: 1'b1, sck_p: 1'b0, start: 1'b0, stop: 1'b0};
        else        st_q <= st_d;
    end

    fe_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .sck_s_i  (sck_s),
        .hold_s_i (hold_s),
        .held_q_o (held_q),
        .held_d_o (held_d)
    );

    assign fall_ok = active && st_q.sck_p && !sck_s && !held_q;
    assign rise_ok = active && !st_q.sck_p && sck_s && !held_d;

    fe_shift #(.W(W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .active_i    (active),
        .fall_ok_i   (fall_ok),
        .rise_ok_i   (rise_ok),
        .si_s_i      (si_s),
        .tx_byte_i   (tx_byte_i),
        .tx_req_i    (tx_req_i),
        .out_phase_o (out_phase),
        .out_bit_o   (so_o),
        .rx_byte_o   (rx_byte_o),
        .rx_valid_o  (rx_valid_o)
    );

    assign so_en_o = active && hold_s && out_phase && !held_q;
    assign start_o = st_q.start;
    assign end_o   = st_q.stop;

    AST_START_END_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && end_o)); // R9
    AST_FROZEN_NO_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q && !hold_s && active) |=> !rx_valid_o); // R7
    AST_IDLE_NO_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && $past(cs_s)) |=> !rx_valid_o); // R1
endmodule

// File: tb/spi_hold_frontend_bench.sv
module spi_hold_frontend_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1, si = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic tx_req = 1'b0;
    logic so, so_en, rx_valid, start_p, end_p;
    logic [7:0] rx_byte;

    int checks = 0, errors = 0, starts = 0, ends = 0, ob = 0;
    bit done = 0;
    logic [7:0] rxq[$];

    always #4 clk = ~clk;

    spi_hold_frontend u_spi_hold_frontend (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .hold_n_i(hold_n),
        .si_i(si), .tx_byte_i(tx_byte), .tx_req_i(tx_req), .so_o(so), .so_en_o(so_en),
        .rx_byte_o(rx_byte), .rx_valid_o(rx_valid), .start_o(start_p), .end_o(end_p)
    );

    // Behavioural reference: pin history plus transfer state.
    bit hc1 = 1, hc2 = 1, hc3 = 1, hk1 = 0, hk2 = 0, hk3 = 0;
    bit hh1 = 1, hh2 = 1, hs1 = 0, hs2 = 0;
    bit m_held = 0, m_out = 0, m_rxv = 0, m_start = 0, m_end = 0, e_en = 0;
    int m_cnt = 0, m_isr = 0, m_osr = 0, m_rxb = 0;

    always @(posedge clk) begin
        bit nheld, fall, rise;
        if (!rst_n) begin
            hc1 = 1; hc2 = 1; hc3 = 1; hk1 = 0; hk2 = 0; hk3 = 0;
            hh1 = 1; hh2 = 1; hs1 = 0; hs2 = 0;
            m_held = 0; m_out = 0; m_rxv = 0; m_start = 0; m_end = 0;
            m_cnt = 0; m_isr = 0; m_osr = 0; m_rxb = 0; e_en = 0;
        end else begin
            m_start = hc3 && !hc2;
            m_end = !hc3 && hc2;
            m_rxv = 0;
            if (hc2) begin
                m_held = 0; m_out = 0; m_cnt = 0;
            end else begin
                nheld = hk2 ? !hh2 : m_held;
                fall = hk3 && !hk2 && !m_held;
                rise = !hk3 && hk2 && !nheld;
                if (fall && !m_out) begin
                    m_isr = ((m_isr << 1) | hs2) & 255;
                    if (m_cnt == 7) begin m_rxv = 1; m_rxb = m_isr; end
                    m_cnt = (m_cnt + 1) % 8;
                end
                if (rise) begin
                    if (!m_out) begin
                        if (m_cnt == 0 && tx_req) begin
                            m_out = 1; m_osr = tx_byte; m_cnt = 1;
                        end
                    end else begin
                        m_osr = (m_cnt == 0) ? tx_byte : ((m_osr << 1) & 255);
                        m_cnt = (m_cnt + 1) % 8;
                    end
                end
                m_held = nheld;
            end
            e_en = m_out && !m_held && hh1 && !hc1;
            hc3 = hc2; hc2 = hc1; hc1 = cs_n;
            hk3 = hk2; hk2 = hk1; hk1 = sck;
            hh2 = hh1; hh1 = hold_n;
            hs2 = hs1; hs1 = si;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the reference.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(so_en == e_en, "R3/R8 so_en", so_en, e_en);
            if (e_en) chk(so == m_osr[7], "R4 so", so, m_osr[7]);
            chk(rx_valid == m_rxv, "R2 rx_valid", rx_valid, m_rxv);
            if (m_rxv) chk(rx_byte == m_rxb[7:0], "R2 rx_byte", rx_byte, m_rxb);
            chk(start_p == m_start, "R9 start", start_p, m_start);
            chk(end_p == m_end, "R9 end", end_p, m_end);
            if (rx_valid) rxq.push_back(rx_byte);
            if (start_p) starts++;
            if (end_p) ends++;
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fall_b(input bit b);
        si = b; wt(2);
        if (so_en) ob = ((ob << 1) | so) & 255;
        sck = 0; wt(4);
    endtask

    task automatic rise_t();
        sck = 1; wt(4);
    endtask

    task automatic send(input logic [7:0] v, input bit idle_low);
        for (int i = 7; i >= 0; i--) begin
            if (idle_low) begin rise_t(); fall_b(v[i]); end
            else begin fall_b(v[i]); rise_t(); end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1; errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wt(5); rst_n = 1; wt(2);
        chk(so_en == 0 && rx_valid == 0, "R3 reset outputs", {so_en, rx_valid}, 0);

        // Idle-low clock: command in, then two reply bytes.
        cs_n = 0; wt(4);
        send(8'hA5, 1); wt(4);
        chk(rxq.size() == 1 && rxq[0] == 8'hA5, "R2 byte A5", rxq.size() ? rxq[0] : 0, 8'hA5);
        tx_req = 1; tx_byte = 8'h3C; ob = 0;
        for (int i = 0; i < 8; i++) begin
            rise_t(); if (i == 0) tx_byte = 8'hC3; fall_b(1);
        end
        chk(ob == 8'h3C, "R4 first reply", ob, 8'h3C);
        ob = 0;
        for (int i = 0; i < 8; i++) begin rise_t(); fall_b(i[0]); end
        chk(ob == 8'hC3, "R10 streamed reply", ob, 8'hC3);
        chk(rxq.size() == 1, "R4 input ignored", rxq.size(), 1);
        hold_n = 0; wt(4);
        chk(so_en == 0, "R8 hold forces release", so_en, 0);
        hold_n = 1; wt(4);
        chk(so_en == 1, "R6 hold not entered with clock low", so_en, 1);
        cs_n = 1; tx_req = 0; wt(6);
        chk(ends == 1, "R9 end pulse", ends, 1);

        // Activity with chip select high.
        send(8'hFF, 1); wt(4);
        chk(rxq.size() == 1 && so_en == 0, "R1 deselected", rxq.size(), 1);

        // Idle-high clock.
        sck = 1; wt(4); cs_n = 0; wt(4);
        send(8'h5A, 0); wt(4);
        chk(rxq.size() == 2 && rxq[1] == 8'h5A, "R5 idle-high byte", rxq.size() > 1 ? rxq[1] : 0, 8'h5A);
        cs_n = 1; wt(6); sck = 0; wt(4);

        // Hold entered while clock is high (immediate), 0x96.
        cs_n = 0; wt(4);
        for (int i = 7; i >= 5; i--) begin rise_t(); fall_b(1'((8'h96 >> i) & 1)); end
        rise_t(); hold_n = 0; wt(4);
        fall_b(1); rise_t(); fall_b(0); rise_t();
        hold_n = 1; wt(4);
        fall_b(1'((8'h96 >> 4) & 1));
        for (int i = 3; i >= 0; i--) begin rise_t(); fall_b(1'((8'h96 >> i) & 1)); end
        wt(4);
        chk(rxq.size() == 3 && rxq[2] == 8'h96, "R7 held byte resumes", rxq.size() > 2 ? rxq[2] : 0, 8'h96);

        // Hold requested while clock is low (deferred), 0x3B.
        for (int i = 7; i >= 4; i--) begin rise_t(); fall_b(1'((8'h3B >> i) & 1)); end
        hold_n = 0; wt(4);
        rise_t(); fall_b(1); rise_t(); fall_b(0);
        hold_n = 1; wt(4);
        rise_t();
        fall_b(1'((8'h3B >> 3) & 1));
        for (int i = 2; i >= 0; i--) begin rise_t(); fall_b(1'((8'h3B >> i) & 1)); end
        wt(4);
        chk(rxq.size() == 4 && rxq[3] == 8'h3B, "R6 deferred hold byte", rxq.size() > 3 ? rxq[3] : 0, 8'h3B);

        // Abort mid-byte, then a clean byte.
        rise_t(); fall_b(1); rise_t(); fall_b(1); rise_t(); fall_b(0);
        cs_n = 1; wt(6); cs_n = 0; wt(4);
        send(8'h81, 1); wt(4);
        chk(rxq.size() == 5 && rxq[4] == 8'h81, "R9 abort clears count", rxq.size() > 4 ? rxq[4] : 0, 8'h81);
        cs_n = 1; wt(6);
        chk(starts == 4 && ends == 4, "R9 pulse counts", starts * 16 + ends, 8'h44);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule